// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the byte-level protocol engine of a two-wire (I2C) serial memory slave holding 4096 bytes. A bus front end, which is not part of this block, turns the SCL and SDA pins into one-cycle event pulses: start, stop, SCL rising with the sampled SDA level, and SCL falling. The engine answers with a single open-drain enable that pulls SDA low. It decodes the control byte and the two word-address bytes. It keeps a 12-bit address pointer that advances after every byte read or written. It collects written bytes in a 32-byte page buffer and copies that buffer into a synchronous RAM during a self-timed programming cycle.

Three strap inputs select which of eight devices on the bus this one is. A write-lock input blocks all programming. While a programming cycle runs, the engine acknowledges nothing, so a master can poll with write control bytes until one is acknowledged. Event pulses must be at least two clock cycles apart. The programming cycle length must be at least the page size.

Top module: `sermem_slave`

## Requirements
- R1: A control byte is received MSB first as bits 7..4 = 1010, bits 3..1 = device select, bit 0 = direction (1 read, 0 write). It is acknowledged only when the tag is 1010 and the select bits equal `dev_sel`. Otherwise it gets no ACK, and every later byte up to the next start is also left unacknowledged.
- R2: `sda_oe` is low out of reset. An acknowledge sets `sda_oe` after the SCL fall that ends the eighth bit and holds it through the ninth clock's high phase. It is cleared after the ninth SCL fall.
- R3: In a write, the first address byte supplies pointer bits 11..8 from its bits 3..0; its bits 7..4 are ignored. The second address byte supplies bits 7..0. Each data byte is stored at the pointer, and then only the pointer's low five bits increment, wrapping inside the 32-byte page.
- R4: A stop that arrives at a byte boundary after at least one data byte starts a programming cycle of `PROG_CYCLES` clocks. During that cycle no control byte is acknowledged. The first ACK after the cycle ends shows that the data is in the array.
- R5: A read control byte with no address phase returns the byte at the pointer, which is the last accessed address plus one, whether that access was a read or a write.
- R6: A write header followed by a repeated start and a read control byte returns the byte at the address just sent. The repeated start starts no programming.
- R7: In a read, a master ACK (SDA low in the ninth clock) makes the engine send the next byte. A master NACK makes it release SDA and ignore the bus until the next start or stop.
- R8: During reads the pointer counts through the whole array and wraps from 0xFFF to 0x000.
- R9: While `wr_lock` is high, data bytes are still acknowledged but nothing is programmed and no programming cycle starts. Reads work normally.
- R10: A start, or a stop, that arrives two or more bits into a byte aborts the transfer, with no programming. The engine then waits for a control byte.
- R11: Read data goes out MSB first. `sda_oe` changes only in the cycle after an SCL-fall, start or stop event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start (or repeated start) seen on the bus, one-cycle pulse |
| bus_stop | input | 1 | Stop seen on the bus, one-cycle pulse |
| scl_rise | input | 1 | SCL rising edge, one-cycle pulse; `sda_in` is valid with it |
| scl_fall | input | 1 | SCL falling edge, one-cycle pulse |
| sda_in | input | 1 | Sampled SDA line level at the SCL rise |
| dev_sel | input | 3 | Device select strap compared with control bits 3..1 |
| wr_lock | input | 1 | High inhibits all programming |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |

## Verification
A behavioural model of the memory, the pointer and the page wrap predicts every byte read back. The test patterns are chosen to separate the failure modes:
- Control bytes with a wrong tag or a wrong select show whether the address decode is complete.
- A full 32-byte page write with junk in the high nibble of the first address byte, followed by a current-address read, exposes wrong pointer widths and page wraps.
- A short write that crosses a page end separates in-page wrapping from carry into the next page.
- Sequential reads across 0xFFF test the full-width wrap.
- Asymmetric data values tell MSB-first order from LSB-first order.
- Polling right after a stop, locked writes, and transfers cut off mid-byte each separate real programming from skipped programming, through ACK timing and data read back afterwards.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    // Fixed device-type tag carried in control bits 7..4
    localparam logic [3:0] CTRL_TAG = 4'b1010;
    // Bit counter values: eighth data bit sampled, ninth clock sampled
    localparam logic [3:0] CNT_BYTE = 4'd8;
    localparam logic [3:0] CNT_ACK  = 4'd9;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_AHI,
        PH_ALO,
        PH_WDAT,
        PH_RDAT
    } phase_t;

    typedef struct packed {
        logic [3:0] tag;
        logic [2:0] sel;
        logic       rd;
    } ctrl_t;

    function automatic logic ctrl_hit(ctrl_t c, logic [2:0] strap);
        return (c.tag == CTRL_TAG) && (c.sel == strap);
    endfunction

endpackage

// File: rtl/sermem_array.sv
module sermem_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/sermem_pagebuf.sv
module sermem_pagebuf #(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 200
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_en,
    input  logic [PAGE_W-1:0]        ld_idx,
    input  logic [7:0]               ld_data,
    input  logic                     clr,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    output logic                     busy,
    output logic                     arr_we,
    output logic [ADDR_W-1:0]        arr_waddr,
    output logic [7:0]               arr_wdata
);
    localparam int PAGE  = 1 << PAGE_W;
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [7:0]               slot [PAGE];
    logic [PAGE-1:0]          filled;
    logic [CNT_W-1:0]         timer;
    logic [ADDR_W-PAGE_W-1:0] base;
    logic [PAGE_W-1:0]        cur;

    assign cur       = timer[PAGE_W-1:0];
    assign arr_we    = busy && (int'(timer) < PAGE) && filled[cur];
    assign arr_waddr = {base, cur};
    assign arr_wdata = slot[cur];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            timer  <= '0;
            filled <= '0;
            base   <= '0;
        end else if (busy) begin
            timer <= timer + 1'b1;
            if (int'(timer) == PROG_CYCLES - 1) begin
                busy   <= 1'b0;
                filled <= '0;
            end
        end else begin
            if (commit) begin
                busy  <= 1'b1;
                timer <= '0;
                base  <= commit_page;
            end
            if (clr) begin
                filled <= '0;
            end
            if (ld_en) begin
                filled[ld_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en) begin
            slot[ld_idx] <= ld_data;
        end
    end

    AST_NO_LOAD_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ld_en |-> !busy) else $error("page load during programming"); // R4
    AST_NO_COMMIT_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        commit |-> !busy) else $error("commit during programming"); // R4
endmodule

// File: rtl/sermem_proto.sv
module sermem_proto
    import sermem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ev_start,
    input  logic                     ev_stop,
    input  logic                     ev_rise,
    input  logic                     ev_fall,
    input  logic                     bit_in,
    input  logic [2:0]               sel,
    input  logic                     wr_lock,
    input  logic                     busy,
    input  logic [7:0]               rd_data,
    output logic                     sda_oe,
    output logic [ADDR_W-1:0]        ptr,
    output logic                     ld_en,
    output logic [PAGE_W-1:0]        ld_idx,
    output logic [7:0]               ld_data,
    output logic                     clr,
    output logic                     commit,
    output logic [ADDR_W-PAGE_W-1:0] commit_page
);
    localparam int HI_W = ADDR_W - 8;

    phase_t          ph;
    phase_t          nxt;
    logic [3:0]      cnt;
    logic [7:0]      shreg;
    logic [HI_W-1:0] ahi;
    logic            pend;
    logic            mack;
    ctrl_t           cb;
    logic            byte_end;
    logic            ack_end;
    logic            at_boundary;

    assign cb          = ctrl_t'(shreg);
    assign byte_end    = ev_fall && (cnt == CNT_BYTE);
    assign ack_end     = ev_fall && (cnt == CNT_ACK);
    // a stop's own SCL rise may count as one bit of the next byte
    assign at_boundary = (cnt <= 4'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph          <= PH_IDLE;
            nxt         <= PH_IDLE;
            cnt         <= '0;
            shreg       <= '0;
            ahi         <= '0;
            ptr         <= '0;
            pend        <= 1'b0;
            mack        <= 1'b1;
            sda_oe      <= 1'b0;
            ld_en       <= 1'b0;
            ld_idx      <= '0;
            ld_data     <= '0;
            clr         <= 1'b0;
            commit      <= 1'b0;
            commit_page <= '0;
        end else begin
            ld_en  <= 1'b0;
            clr    <= 1'b0;
            commit <= 1'b0;
            if (ev_start) begin
                ph     <= PH_CTRL;
                cnt    <= '0;
                sda_oe <= 1'b0;
                pend   <= 1'b0;
            end else if (ev_stop) begin
                if (ph == PH_WDAT && at_boundary && pend && !wr_lock) begin
                    commit      <= 1'b1;
                    commit_page <= ptr[ADDR_W-1:PAGE_W];
                end
                ph     <= PH_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
                pend   <= 1'b0;
            end else if (ph != PH_IDLE) begin
                if (ev_rise) begin
                    if (cnt < CNT_BYTE && ph != PH_RDAT) begin
                        shreg <= {shreg[6:0], bit_in};
                    end
                    if (cnt == CNT_BYTE && ph == PH_RDAT) begin
                        mack <= bit_in;
                    end
                    if (cnt < CNT_ACK) begin
                        cnt <= cnt + 1'b1;
                    end
                end else if (byte_end) begin
                    unique case (ph)
                        PH_CTRL: begin
                            if (ctrl_hit(cb, sel) && !busy) begin
                                sda_oe <= 1'b1;
                                nxt    <= cb.rd ? PH_RDAT : PH_AHI;
                            end else begin
                                ph  <= PH_IDLE;
                                cnt <= '0;
                            end
                        end
                        PH_AHI: begin
                            ahi    <= shreg[HI_W-1:0];
                            sda_oe <= 1'b1;
                            nxt    <= PH_ALO;
                        end
                        PH_ALO: begin
                            ptr    <= {ahi, shreg};
                            clr    <= 1'b1;
                            sda_oe <= 1'b1;
                            nxt    <= PH_WDAT;
                        end
                        PH_WDAT: begin
                            sda_oe <= 1'b1;
                            nxt    <= PH_WDAT;
                            if (!wr_lock) begin
                                ld_en   <= 1'b1;
                                ld_idx  <= ptr[PAGE_W-1:0];
                                ld_data <= shreg;
                                pend    <= 1'b1;
                            end
                            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                        end
                        PH_RDAT: begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                        end
                        default: begin
                            ph <= PH_IDLE;
                        end
                    endcase
                end else if (ack_end) begin
                    cnt <= '0;
                    if (ph == PH_RDAT) begin
                        if (!mack) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            ph     <= PH_IDLE;
                            sda_oe <= 1'b0;
                        end
                    end else begin
                        ph <= nxt;
                        if (nxt == PH_RDAT) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end else if (ev_fall && ph == PH_RDAT && cnt != '0) begin
                    shreg  <= {shreg[6:0], 1'b0};
                    sda_oe <= ~shreg[6];
                end
            end
        end
    end

    AST_OE_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        $changed(sda_oe) |-> $past(ev_fall || ev_start || ev_stop))
        else $error("SDA drive moved without an SCL fall"); // R11
    AST_SILENT_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_CTRL && byte_end && busy && !ev_start && !ev_stop) |=> !sda_oe)
        else $error("acknowledge during programming"); // R4
    AST_PTR_READ_STEP: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RDAT && byte_end && !ev_start && !ev_stop) |=> ptr == $past(ptr) + 1'b1)
        else $error("read pointer did not advance"); // R8
endmodule

// File: rtl/sermem_slave.sv
module sermem_slave #(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_in,
    input  logic [2:0] dev_sel,
    input  logic       wr_lock,
    output logic       sda_oe
);
    localparam int PAGE_SEL_W = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0]     ptr;
    logic [7:0]            rd_data;
    logic                  ld_en;
    logic [PAGE_W-1:0]     ld_idx;
    logic [7:0]            ld_data;
    logic                  clr;
    logic                  commit;
    logic [PAGE_SEL_W-1:0] commit_page;
    logic                  busy;
    logic                  arr_we;
    logic [ADDR_W-1:0]     arr_waddr;
    logic [7:0]            arr_wdata;

    sermem_proto #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
        .clk(clk), .rst(rst),
        .ev_start(bus_start), .ev_stop(bus_stop),
        .ev_rise(scl_rise), .ev_fall(scl_fall), .bit_in(sda_in),
        .sel(dev_sel), .wr_lock(wr_lock), .busy(busy), .rd_data(rd_data),
        .sda_oe(sda_oe), .ptr(ptr),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .clr(clr), .commit(commit), .commit_page(commit_page)
    );

    sermem_pagebuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_page (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .clr(clr), .commit(commit), .commit_page(commit_page),
        .busy(busy), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
    );

    sermem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(ptr), .rdata(rd_data)
    );

    AST_LOCK_BLOCKS_CYCLE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wr_lock))
        else $error("programming started while locked"); // R9
endmodule

// File: tb/sim_sermem_slave.sv
module sim_sermem_slave;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_start = 1'b0, bus_stop = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
    logic sda_in = 1'b1;
    logic [2:0] dev_sel = SEL;
    logic wr_lock = 1'b0;
    logic sda_oe;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] mem_m [int];
    int ptr_m = 0;

    always #5 clk = ~clk;

    sermem_slave u0 (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .dev_sel(dev_sel), .wr_lock(wr_lock), .sda_oe(sda_oe)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl(logic rd);
        return {4'b1010, SEL, rd};
    endfunction

    task automatic bit_x(input logic mb, output logic ln);
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
        repeat (3) @(negedge clk);
        ln = mb & ~sda_oe;
        sda_in = ln;
        scl_rise = 1'b1;
        @(negedge clk) scl_rise = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic ln;
        for (int i = 7; i >= 0; i--) bit_x(b[i], ln);
        bit_x(1'b1, ln);
        ack = !ln;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        logic ln;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_x(1'b1, ln);
            b = {b[6:0], ln};
        end
        bit_x(nack, ln);
    endtask

    task automatic pulse_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_rstart();
        logic ln;
        bit_x(1'b1, ln);
        pulse_start();
    endtask

    task automatic do_stop();
        logic ln;
        bit_x(1'b0, ln);
        pulse_stop();
    endtask

    task automatic send_header(int addr, logic [3:0] junk, string req);
        logic ack;
        send_byte(ctl(1'b0), ack);
        check({req, " write control ack"}, ack, 1);
        send_byte({junk, 4'(addr >> 8)}, ack);
        check({req, " high address ack"}, ack, 1);
        send_byte(8'(addr), ack);
        check({req, " low address ack"}, ack, 1);
    endtask

    task automatic wr_txn(int addr, logic [7:0] d[$], logic [3:0] junk, string req);
        logic ack;
        int a;
        pulse_start();
        send_header(addr, junk, req);
        for (int i = 0; i < d.size(); i++) begin
            send_byte(d[i], ack);
            check({req, " data ack"}, ack, 1);
            a = (addr & 'hFE0) | ((addr + i) & 'h1F);
            if (!wr_lock) mem_m[a] = d[i];
        end
        ptr_m = (addr & 'hFE0) | ((addr + d.size()) & 'h1F);
        do_stop();
    endtask

    task automatic wait_ready(output int polls);
        logic ack;
        polls = 0;
        forever begin
            pulse_start();
            send_byte(ctl(1'b0), ack);
            do_stop();
            if (ack || polls > 100) break;
            polls++;
        end
    endtask

    // mode 0: current address, 1: random (write header first), 2: start already issued
    task automatic rd_txn(int mode, int addr, int n, string req);
        logic ack;
        logic ln;
        logic [7:0] b;
        if (mode == 1) begin
            pulse_start();
            send_header(addr, 4'h0, req);
            ptr_m = addr;
            do_rstart();
        end else if (mode == 0) begin
            pulse_start();
        end
        send_byte(ctl(1'b1), ack);
        check({req, " read control ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, (i == n - 1));
            check({req, " read data"}, int'(b), int'(mem_m[ptr_m]));
            ptr_m = (ptr_m + 1) & 'hFFF;
        end
        bit_x(1'b1, ln);
        check({req, " R7 SDA released after NACK"}, ln, 1);
        pulse_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        int polls;
        logic [7:0] pg[$];
        logic ln;

        repeat (4) @(negedge clk);
        check("R2 reset state of sda_oe", sda_oe, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 idle after reset", sda_oe, 0);

        // R1: wrong select, then further bytes ignored; wrong tag
        pulse_start();
        send_byte({4'b1010, 3'b100, 1'b0}, ack);
        check("R1 wrong select no ack", ack, 0);
        send_byte(8'h00, ack);
        check("R1 later byte ignored", ack, 0);
        do_stop();
        pulse_start();
        send_byte({4'b1011, SEL, 1'b0}, ack);
        check("R1 wrong tag no ack", ack, 0);
        do_stop();

        // R2: ACK held through ninth high phase
        pulse_start();
        send_byte(ctl(1'b0), ack);
        check("R2 control ack", ack, 1);
        check("R2 drive held after ninth rise", sda_oe, 1);
        do_stop();
        wait_ready(polls);
        check("R2 no programming from bare header", polls, 0);

        // R3: full page at 0xFE0 with junk high nibble, R4 polling
        pg = {};
        for (int i = 0; i < 32; i++) pg.push_back(8'(8'h40 + i * 3));
        wr_txn('hFE0, pg, 4'hC, "R3");
        wait_ready(polls);
        check("R4 first poll refused", int'(polls >= 1), 1);
        check("R4 poll eventually acked", int'(polls <= 100), 1);

        // R5/R11: current read, pointer wrapped back to page start
        check("R3 pointer wrapped in page", ptr_m, 'hFE0);
        rd_txn(0, 0, 1, "R5 R11 current read");

        // R3: in-page wrap 0x01E -> 0x000
        wr_txn('h01E, '{8'h11, 8'h22, 8'h33, 8'h44}, 4'h0, "R3 wrap write");
        wait_ready(polls);
        rd_txn(1, 'h000, 1, "R3 page wrap data");

        // R6 random read, then R5 current read follows it
        rd_txn(1, 'hFE5, 1, "R6 random read");
        rd_txn(0, 0, 1, "R5 after read");

        // R7/R8 sequential read across top of array
        rd_txn(1, 'hFFE, 4, "R7 R8 sequential wrap");

        // R5 current read after write
        wr_txn('h051, '{8'hA5}, 4'h0, "R5 setup");
        wait_ready(polls);
        wr_txn('h050, '{8'h5A}, 4'h0, "R5 setup");
        wait_ready(polls);
        check("R5 pointer after write", ptr_m, 'h051);
        rd_txn(0, 0, 1, "R5 after write");

        // R9 write lock
        wr_lock = 1'b1;
        wr_txn('h050, '{8'hFF}, 4'h0, "R9 locked");
        wait_ready(polls);
        check("R9 no programming cycle", polls, 0);
        rd_txn(1, 'h050, 1, "R9 data kept and read works");
        wr_lock = 1'b0;

        // R10 stop mid-byte
        pulse_start();
        send_header('h051, 4'h0, "R10");
        send_byte(8'h77, ack);
        check("R10 data ack", ack, 1);
        for (int i = 0; i < 4; i++) bit_x(1'b0, ln);
        pulse_stop();
        wait_ready(polls);
        check("R10 stop mid-byte no cycle", polls, 0);
        rd_txn(1, 'h051, 1, "R10 data unchanged");

        // R10 start mid-byte, then current read
        pulse_start();
        send_header('h050, 4'h0, "R10");
        for (int i = 0; i < 3; i++) bit_x(1'b1, ln);
        pulse_start();
        ptr_m = 'h050;
        rd_txn(2, 0, 1, "R10 start mid-byte");
        wait_ready(polls);
        check("R10 start mid-byte no cycle", polls, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule